// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

The block holds a 16-bit timer that advances on cycles where a tick enable is high. The timer is compared for equality with a software-written reference value on every cycle. When the two become equal, the block takes the action chosen by a 4-bit mode code. It can drive an output latch high, drive it low or invert it. It can also only raise an interrupt flag, or fire an event pulse that starts an analog-to-digital conversion and restarts the timer.

Actions are edge-qualified: they fire once, on the first cycle of a match. In event mode the timer holds the reference value for the rest of the current tick period. It then returns to zero on the next tick, so the reference acts as a programmable period of reference+1 ticks. That restart is dropped if the reference is rewritten before the tick so that the match no longer holds. All logic runs on one clock with an active-low asynchronous reset.

Top module: `cmp_event_unit`

## Requirements
- R1: The timer increments by one on each clock edge where `tick_i` is high, and holds its value otherwise, except for the event restart of R7.
- R2: A match is exact equality of the timer and the reference. Actions fire only on the first cycle of a match, so a timer stalled on the reference value acts once.
- R3: Mode 4'b1000 sets the latch, mode 4'b1001 clears it and mode 4'b0010 inverts it, on the clock edge that ends the first match cycle.
- R4: Mode 4'b1010 sets the interrupt flag on a match and leaves the latch unchanged.
- R5: Modes 4'b0010, 4'b1000, 4'b1001, 4'b1010 and 4'b1011 all set the interrupt flag on a match. Mode 4'b0000 and every other code take no action.
- R6: Mode 4'b1011 raises `trig_o` combinationally during the first match cycle, for one cycle. `adc_start_o` equals `trig_o` gated by `adc_en_i`, and the latch is unchanged.
- R7: In mode 4'b1011 the timer is loaded with zero instead of incrementing on the first tick after the match begins. The period is therefore reference+1 ticks.
- R8: If the reference changes so that the match no longer holds before that tick, the timer increments normally and is not restarted.
- R9: `ovf_o` is set when a tick wraps the timer from 16'hFFFF to zero, and is cleared by `ovf_clr_i` (a set in the same cycle wins). An event restart never sets it.
- R10: Writing 4'b0000 to the mode register forces the latch low on that clock edge.
- R11: `irq_clr_i` clears the interrupt flag. If a clear and a new match fall in the same cycle, the flag stays set.
- R12: After reset the timer, reference, mode, latch and both flags are zero, and `trig_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer advance enable |
| ref_wr_i | input | 1 | Reference register write strobe |
| ref_wdata_i | input | 16 | Reference write data |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 4 | Mode write data |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| adc_en_i | input | 1 | Conversion enable, gates the start pulse |
| timer_o | output | 16 | Current timer value |
| latch_o | output | 1 | Compare output latch |
| irq_o | output | 1 | Compare interrupt flag |
| ovf_o | output | 1 | Timer overflow flag |
| trig_o | output | 1 | Special event pulse |
| adc_start_o | output | 1 | Conversion start pulse |

## Verification
Two collisions are provoked on purpose. In the first, a flag clear strobe is driven in the very cycle a new match is first seen, and the flag must still read set on the next sample. In the second, the reference is set to 16'hFFFF in event mode, so the event restart and the natural wrap of the timer fall on the same tick. The timer must read zero afterwards while the overflow flag stays clear. A separate plain wrap in a mode with no action confirms that the flag does rise when no restart is involved.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned MODE_W = 4;
  typedef enum logic [MODE_W-1:0] {
    MODE_OFF    = 4'b0000,
    MODE_TOGGLE = 4'b0010,
    MODE_SET    = 4'b1000,
    MODE_CLR    = 4'b1001,
    MODE_IRQ    = 4'b1010,
    MODE_EVENT  = 4'b1011
  } cmp_mode_e;
endpackage

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          ovf_clr_i,
  output logic [TW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q;
  logic          ovf_q;
  logic          wrap;

  assign wrap = tick_i && !restart_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= restart_i ? '0 : cnt_q + TW'(1);
      if (wrap)           ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] ref_i,
  output logic          hit_o,
  output logic          rise_o
);
  logic hit_q;

  assign hit_o  = (cnt_i == ref_i);
  assign rise_o = hit_o && !hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit_o;
  end
endmodule

// File: rtl/cmp_action.sv
module cmp_action
  import cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              mode_zero_wr_i,
  input  logic              hit_i,
  input  logic              rise_i,
  input  logic              tick_i,
  input  logic              adc_en_i,
  input  logic              irq_clr_i,
  output logic              latch_o,
  output logic              irq_o,
  output logic              trig_o,
  output logic              adc_start_o,
  output logic              restart_o
);
  logic latch_q, irq_q, pend_q;
  logic is_event, is_active;

  assign is_event  = (mode_i == MODE_EVENT);
  assign is_active = (mode_i == MODE_TOGGLE) || (mode_i == MODE_SET) ||
                     (mode_i == MODE_CLR) || (mode_i == MODE_IRQ) || is_event;

  assign trig_o      = is_event && rise_i;
  assign adc_start_o = trig_o && adc_en_i;
  // restart on the first tick while the event match still holds
  assign restart_o   = is_event && hit_i && tick_i && (pend_q || rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= is_event && hit_i && !tick_i && (pend_q || rise_i);
      if (mode_zero_wr_i) latch_q <= 1'b0;
      else if (rise_i) begin
        unique case (mode_i)
          MODE_SET:    latch_q <= 1'b1;
          MODE_CLR:    latch_q <= 1'b0;
          MODE_TOGGLE: latch_q <= !latch_q;
          default:     latch_q <= latch_q;
        endcase
      end
      if (rise_i && is_active) irq_q <= 1'b1;
      else if (irq_clr_i)      irq_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
  import cmp_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ref_wr_i,
  input  logic [TW-1:0]     ref_wdata_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  input  logic              adc_en_i,
  output logic [TW-1:0]     timer_o,
  output logic              latch_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              trig_o,
  output logic              adc_start_o
);
  logic [TW-1:0]     ref_q;
  logic [MODE_W-1:0] mode_q;
  logic [TW-1:0]     cnt;
  logic              hit, rise, restart, mode_zero_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      if (ref_wr_i)  ref_q  <= ref_wdata_i;
      if (mode_wr_i) mode_q <= mode_wdata_i;
    end
  end

  assign mode_zero_wr = mode_wr_i && (mode_wdata_i == MODE_OFF);

  cmp_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .restart_i (restart),
    .ovf_clr_i,
    .cnt_o     (cnt),
    .ovf_o
  );

  cmp_match #(.TW(TW)) u_match (
    .clk_i, .rst_ni,
    .cnt_i  (cnt),
    .ref_i  (ref_q),
    .hit_o  (hit),
    .rise_o (rise)
  );

  cmp_action u_action (
    .clk_i, .rst_ni,
    .mode_i         (mode_q),
    .mode_zero_wr_i (mode_zero_wr),
    .hit_i          (hit),
    .rise_i         (rise),
    .tick_i,
    .adc_en_i,
    .irq_clr_i,
    .latch_o, .irq_o, .trig_o, .adc_start_o,
    .restart_o      (restart)
  );

  assign timer_o = cnt;
endmodule

// File: rtl/cmp_event_unit_chk.sv
module cmp_event_unit_chk #(
  parameter int unsigned TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          mode_wr_i,
  input logic [3:0]    mode_wdata_i,
  input logic          irq_clr_i,
  input logic [TW-1:0] timer_o,
  input logic          latch_o,
  input logic          irq_o,
  input logic          ovf_o,
  input logic          trig_o,
  input logic          adc_start_o
);
  // R1
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(timer_o));
  // R1
  timer_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (timer_o == $past(timer_o) + TW'(1)) || (timer_o == '0));
  // R6
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  // R6
  adc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> trig_o);
  // R9
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($past(timer_o) == {TW{1'b1}}) && $past(tick_i) && (timer_o == '0));
  // R10
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && mode_wdata_i == 4'b0000) |=> !latch_o);
  // R11
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_clr_i));
endmodule

bind cmp_event_unit cmp_event_unit_chk #(.TW(TW)) u_chk (
  .clk_i, .rst_ni, .tick_i, .mode_wr_i, .mode_wdata_i, .irq_clr_i,
  .timer_o, .latch_o, .irq_o, .ovf_o, .trig_o, .adc_start_o
);

// File: tb/tb_cmp_event_unit.sv
module tb_cmp_event_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, ref_wr = 1'b0, mode_wr = 1'b0;
  logic        irq_clr = 1'b0, ovf_clr = 1'b0, adc_en = 1'b0;
  logic [15:0] ref_wdata = '0;
  logic [3:0]  mode_wdata = '0;
  logic [15:0] timer;
  logic        latch, irq, ovf, trig, adc_start;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;

  cmp_event_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .ref_wr_i(ref_wr), .ref_wdata_i(ref_wdata),
    .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
    .irq_clr_i(irq_clr), .ovf_clr_i(ovf_clr), .adc_en_i(adc_en),
    .timer_o(timer), .latch_o(latch), .irq_o(irq), .ovf_o(ovf),
    .trig_o(trig), .adc_start_o(adc_start)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_ref(input logic [15:0] v);
    ref_wr = 1'b1; ref_wdata = v;
    @(negedge clk);
    ref_wr = 1'b0;
  endtask

  task automatic wr_mode(input logic [3:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 timer", timer, 0);
    check("R12 latch", latch, 0);
    check("R12 irq", irq, 0);
    check("R12 ovf", ovf, 0);
    check("R12 trig", trig, 0);
  endtask

  task automatic t_count();
    do_ticks(5);
    check("R1 count", timer, 5);
    step(3);
    check("R1 hold", timer, 5);
  endtask

  task automatic t_set_clr();
    wr_mode(4'b1000); wr_ref(16'd8);
    do_ticks(3); step(1);
    check("R3 set latch", latch, 1);
    check("R5 set irq", irq, 1);
    clr_irq();
    check("R11 clear", irq, 0);
    wr_mode(4'b1001); wr_ref(16'd12);
    do_ticks(4); step(1);
    check("R3 clr latch", latch, 0);
  endtask

  task automatic t_toggle_stall();
    wr_mode(4'b0010); wr_ref(16'd14);
    do_ticks(2); step(5);
    check("R2 stalled toggles once", latch, 1);
    wr_ref(16'd16);
    do_ticks(2); step(1);
    check("R3 toggle back", latch, 0);
  endtask

  task automatic t_irq_only();
    wr_mode(4'b1000); wr_ref(16'd18);
    do_ticks(2); step(1);
    wr_mode(4'b1010); clr_irq(); wr_ref(16'd20);
    do_ticks(2); step(1);
    check("R4 irq", irq, 1);
    check("R4 latch kept", latch, 1);
    wr_mode(4'b0101); clr_irq(); wr_ref(16'd22);
    do_ticks(2); step(1);
    check("R5 other code no irq", irq, 0);
    check("R5 other code latch", latch, 1);
    wr_mode(4'b0000);
    check("R10 mode off latch", latch, 0);
  endtask

  task automatic t_clr_collide();
    wr_mode(4'b1010); wr_ref(16'd24);
    do_ticks(2);
    irq_clr = 1'b1;           // same cycle as first match
    @(negedge clk);
    irq_clr = 1'b0;
    check("R11 set wins", irq, 1);
    clr_irq();
    check("R11 plain clear", irq, 0);
  endtask

  task automatic t_event();
    wr_mode(4'b1011); adc_en = 1'b1; wr_ref(16'd30);
    do_ticks(6);
    check("R6 trig", trig, 1);
    check("R6 adc start", adc_start, 1);
    check("R7 value held", timer, 30);
    step(1);
    check("R6 one pulse", trig, 0);
    check("R7 no restart without tick", timer, 30);
    do_ticks(1);
    check("R7 restart", timer, 0);
    check("R9 no ovf on restart", ovf, 0);
    check("R6 latch kept", latch, 0);
    check("R5 event irq", irq, 1);
    adc_en = 1'b0;
    do_ticks(30);
    check("R6 trig period", trig, 1);
    check("R6 adc gated", adc_start, 0);
    do_ticks(1);
    check("R7 period", timer, 0);
  endtask

  task automatic t_cancel();
    do_ticks(30);
    check("R8 match reached", timer, 30);
    wr_ref(16'd40);
    do_ticks(1);
    check("R8 restart cancelled", timer, 31);
  endtask

  task automatic t_wrap();
    wr_mode(4'b0101);
    do_ticks(65535 - 31);
    check("R1 at max", timer, 16'hFFFF);
    do_ticks(1);
    check("R9 wrap", timer, 0);
    check("R9 ovf set", ovf, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R9 ovf clear", ovf, 0);
    wr_mode(4'b1011); wr_ref(16'hFFFF);
    do_ticks(65535);
    check("R7 event at max", trig, 1);
    do_ticks(1);
    check("R7 restart at max", timer, 0);
    check("R9 restart no ovf", ovf, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_count();
    t_set_clr();
    t_toggle_stall();
    t_irq_only();
    t_clr_collide();
    t_event();
    t_cancel();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule